// File: doc/BRIEF.md
# Branch Record Ring with Newest-First Read Port

The block stores control-flow records in a circular array. Each record holds a source address with a valid flag, a target address and a four-bit kind code. A write pointer marks the next free slot. Whenever a qualified record request arrives, the record is stored at that slot and the pointer moves forward. Deciding which events qualify is done upstream. A run-time depth select sets how many slots are in use: 16 shifted left by the select value.

Software reads through a logical index, and index 0 is always the most recent record. The block turns the index into a physical slot relative to the write pointer, so the array looks as if it shifts by one place on every new record.

A call-stack emulation mode is also available. In this mode a return request pops the newest record instead of adding one. A co-routine swap request replaces the newest record in place.

Top module: `brb_ring`

## Requirements
- R1: The active depth is 16 << `depth_sel`. All slot arithmetic and the visible `wr_ptr` are taken modulo the active depth, so the pointer wraps from depth-1 to 0.
- R2: A request (`rec_valid`=1) that is neither a pop nor a swap stores the record at slot `wr_ptr`. On the following cycle `wr_ptr` reads (old+1) modulo depth.
- R3: A stored record reads back with `rd_valid`=1, the request's source, its target with bit 0 (the mispredict flag) forced to 0, and its kind code.
- R4: Logical index e in `rd_idx` reads physical slot (`wr_ptr` - e - 1) modulo depth. The contents appear on the `rd_*` outputs one cycle after the index is presented.
- R5: With `ras_mode`=1, a request with kind 13 (return) moves `wr_ptr` back by one and clears the valid flag of that slot. It stores no new data.
- R6: With `ras_mode`=1, a request with kind 12 (co-routine swap) overwrites the slot at `wr_ptr`-1 with the new record and leaves `wr_ptr` unchanged.
- R7: With `ras_mode`=0, kinds 12 and 13 are stored like any other record (R2).
- R8: Reset clears every valid flag and sets `wr_ptr` to 0.
- R9: A read of the slot that is being written in the same cycle returns the contents that slot held before the write.
- R10: While `rec_valid`=0, neither `wr_ptr` nor any stored record changes, whatever the other request inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| depth_sel | input | SEL_W | Depth select; active depth is 16 << depth_sel |
| ras_mode | input | 1 | Call-stack emulation mode enable |
| rec_valid | input | 1 | Qualified record request this cycle |
| rec_src | input | ADDR_W | Source address of the record |
| rec_dst | input | ADDR_W | Target address; bit 0 is dropped on store |
| rec_type | input | 4 | Kind code (12 swap, 13 return) |
| rd_idx | input | PTR_W | Logical read index, 0 = newest |
| rd_valid | output | 1 | Valid flag of the entry read |
| rd_src | output | ADDR_W | Source address of the entry read |
| rd_dst | output | ADDR_W | Target address of the entry read |
| rd_type | output | 4 | Kind code of the entry read |
| wr_ptr | output | PTR_W | Current write pointer modulo depth |

## Verification
A store and a read can land on the same physical slot in one cycle. The bench provokes this by presenting logical index depth-1 during a push, which maps onto the slot being written. It does the same with index 0 during pops and swaps, which target the newest slot. The behavioural model takes the expected read data from its state before that cycle's update, so a read that returns the new record is reported under R9. Pointer movement is checked in the same cycles, so the write path and the read path are judged against each other cycle by cycle.

// File: rtl/brb_pkg.sv
package brb_pkg;
  localparam int KIND_W = 4;
  localparam logic [KIND_W-1:0] KIND_SWAP = 4'd12;
  localparam logic [KIND_W-1:0] KIND_RET  = 4'd13;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } brb_op_e;
endpackage

// File: rtl/brb_ctl.sv
module brb_ctl
  import brb_pkg::*;
#(
  parameter int PTR_W = 5,
  parameter int SEL_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [KIND_W-1:0] rec_type,
  input  logic              ras_mode,
  input  logic [SEL_W-1:0]  depth_sel,
  output brb_op_e           op,
  output logic [PTR_W-1:0]  mask,
  output logic [PTR_W-1:0]  ptr_eff,
  output logic [PTR_W-1:0]  wr_slot
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic [PTR_W:0]   depth_full;

  always_comb begin
    depth_full = (PTR_W+1)'(16) << depth_sel;
    mask       = PTR_W'(depth_full - 1'b1);
    ptr_eff    = ptr_q & mask;
  end

  always_comb begin
    if (!rec_valid)                            op = OP_IDLE;
    else if (ras_mode && rec_type == KIND_RET)  op = OP_POP;
    else if (ras_mode && rec_type == KIND_SWAP) op = OP_SWAP;
    else                                       op = OP_PUSH;
  end

  always_comb begin
    wr_slot = ptr_eff;
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    unique case (op)
      OP_PUSH: begin
        ptr_d  = (ptr_eff + 1'b1) & mask;
        ptr_en = 1'b1;
      end
      OP_POP: begin
        wr_slot = (ptr_eff - 1'b1) & mask;
        ptr_d   = wr_slot;
        ptr_en  = 1'b1;
      end
      OP_SWAP: wr_slot = (ptr_eff - 1'b1) & mask;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  a_r2_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && $stable(depth_sel)) |=> ptr_eff == (($past(ptr_eff) + 1'b1) & mask));
  a_r5_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && $stable(depth_sel)) |=> ptr_eff == (($past(ptr_eff) - 1'b1) & mask));
  a_r6_swap_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SWAP) |=> ptr_q == $past(ptr_q));
  a_r10_idle_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_valid) |=> $stable(ptr_q));
endmodule

// File: rtl/brb_xlate.sv
module brb_xlate #(
  parameter int PTR_W = 5
) (
  input  logic [PTR_W-1:0] ptr_eff,
  input  logic [PTR_W-1:0] mask,
  input  logic [PTR_W-1:0] idx,
  output logic [PTR_W-1:0] slot
);
  always_comb slot = (ptr_eff - idx - 1'b1) & mask;
endmodule

// File: rtl/brb_array.sv
module brb_array
  import brb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [PTR_W-1:0]  wr_slot,
  input  logic [ADDR_W-1:0] wr_src,
  input  logic [ADDR_W-1:0] wr_dst,
  input  logic [KIND_W-1:0] wr_kind,
  input  logic [PTR_W-1:0]  rd_slot,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic [KIND_W-1:0] rd_kind
);
  localparam int SLOTS = 1 << PTR_W;

  logic [SLOTS-1:0]  vld_q;
  logic [ADDR_W-1:0] src_q  [SLOTS];
  logic [ADDR_W-1:0] dst_q  [SLOTS];
  logic [KIND_W-1:0] kind_q [SLOTS];
  logic [ADDR_W-1:0] dst_clean;

  always_comb dst_clean = {wr_dst[ADDR_W-1:1], 1'b0};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    logic data_en;
    logic vld_en;
    logic vld_d;
    always_comb begin
      hit     = (wr_slot == PTR_W'(s));
      data_en = hit && wr_set;
      vld_en  = hit && (wr_set || wr_clr);
      vld_d   = wr_set;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q[s] <= 1'b0;
      else if (vld_en) vld_q[s] <= vld_d;
    end
    always_ff @(posedge clk) begin
      if (data_en) begin
        src_q[s]  <= wr_src;
        dst_q[s]  <= dst_clean;
        kind_q[s] <= wr_kind;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= vld_q[rd_slot];
  end

  always_ff @(posedge clk) begin
    rd_src  <= src_q[rd_slot];
    rd_dst  <= dst_q[rd_slot];
    rd_kind <= kind_q[rd_slot];
  end

  a_r3_store_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> vld_q[$past(wr_slot)] && !dst_q[$past(wr_slot)][0]);
  a_r5_pop_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !vld_q[$past(wr_slot)]);
  a_r3_set_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set && wr_clr));
endmodule

// File: rtl/brb_ring.sv
module brb_ring
  import brb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 1,
  localparam int PTR_W = 4 + (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  depth_sel,
  input  logic              ras_mode,
  input  logic              rec_valid,
  input  logic [ADDR_W-1:0] rec_src,
  input  logic [ADDR_W-1:0] rec_dst,
  input  logic [3:0]        rec_type,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic [3:0]        rd_type,
  output logic [PTR_W-1:0]  wr_ptr
);
  brb_op_e          op;
  logic [PTR_W-1:0] mask;
  logic [PTR_W-1:0] ptr_eff;
  logic [PTR_W-1:0] wr_slot;
  logic [PTR_W-1:0] rd_slot;
  logic             wr_set;
  logic             wr_clr;

  brb_ctl #(.PTR_W(PTR_W), .SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_type(rec_type),
    .ras_mode(ras_mode), .depth_sel(depth_sel), .op(op), .mask(mask),
    .ptr_eff(ptr_eff), .wr_slot(wr_slot)
  );

  brb_xlate #(.PTR_W(PTR_W)) u_xlate (
    .ptr_eff(ptr_eff), .mask(mask), .idx(rd_idx), .slot(rd_slot)
  );

  always_comb begin
    wr_set = (op == OP_PUSH) || (op == OP_SWAP);
    wr_clr = (op == OP_POP);
    wr_ptr = ptr_eff;
  end

  brb_array #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_slot(wr_slot), .wr_src(rec_src), .wr_dst(rec_dst), .wr_kind(rec_type),
    .rd_slot(rd_slot), .rd_valid(rd_valid), .rd_src(rd_src), .rd_dst(rd_dst),
    .rd_kind(rd_type)
  );

  a_r7_plain_mode_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !ras_mode) |-> op == OP_PUSH);
  a_r1_ptr_in_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr & ~mask) == '0);
endmodule

// File: tb/brb_ring_test.sv
`timescale 1ns/1ps
module brb_ring_test;
  localparam int AW = 32;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [0:0]    depth_sel;
  logic          ras_mode;
  logic          rec_valid;
  logic [AW-1:0] rec_src;
  logic [AW-1:0] rec_dst;
  logic [3:0]    rec_type;
  logic [PW-1:0] rd_idx;
  logic          rd_valid;
  logic [AW-1:0] rd_src;
  logic [AW-1:0] rd_dst;
  logic [3:0]    rd_type;
  logic [PW-1:0] wr_ptr;

  always #10 clk = ~clk;

  brb_ring #(.ADDR_W(AW), .SEL_W(1)) uut (
    .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .ras_mode(ras_mode),
    .rec_valid(rec_valid), .rec_src(rec_src), .rec_dst(rec_dst),
    .rec_type(rec_type), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_src(rd_src), .rd_dst(rd_dst), .rd_type(rd_type), .wr_ptr(wr_ptr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_v [32];
  logic [31:0] m_s [32];
  logic [31:0] m_d [32];
  logic [3:0]  m_t [32];
  int          m_ptr;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, predict from pre-update model, compare at next negedge.
  task automatic step(bit v, logic [31:0] s, logic [31:0] d, logic [3:0] t,
                      bit ras, int idx, string ptag);
    int dep, msk, eff, rs, slot, exp_ptr;
    bit ev; logic [31:0] es, ed; logic [3:0] et;
    bit collide;
    rec_valid = v; rec_src = s; rec_dst = d; rec_type = t;
    ras_mode = ras; rd_idx = PW'(idx);
    dep = 16 << depth_sel; msk = dep - 1;
    eff = m_ptr & msk;
    rs = (eff - (idx & 31) - 1) & msk;
    ev = m_v[rs]; es = m_s[rs]; ed = m_d[rs]; et = m_t[rs];
    collide = 0;
    if (v) begin
      if (ras && t == 4'd13) begin
        slot = (eff - 1) & msk; m_v[slot] = 0; m_ptr = slot;
      end else if (ras && t == 4'd12) begin
        slot = (eff - 1) & msk;
        m_v[slot] = 1; m_s[slot] = s; m_d[slot] = d & ~32'd1; m_t[slot] = t;
      end else begin
        slot = eff;
        m_v[slot] = 1; m_s[slot] = s; m_d[slot] = d & ~32'd1; m_t[slot] = t;
        m_ptr = (eff + 1) & msk;
      end
      collide = (slot == rs);
    end
    exp_ptr = m_ptr & msk;
    @(posedge clk);
    @(negedge clk);
    chk(ptag, 64'(wr_ptr), 64'(exp_ptr));
    chk(collide ? "R9 valid" : "R4 valid", 64'(rd_valid), 64'(ev));
    if (ev) begin
      chk(collide ? "R9 src" : "R3 src", 64'(rd_src), 64'(es));
      chk(collide ? "R9 dst" : "R3 dst", 64'(rd_dst), 64'(ed));
      chk(collide ? "R9 type" : "R3 type", 64'(rd_type), 64'(et));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; depth_sel = 0; ras_mode = 0; rec_valid = 0;
    rec_src = 0; rec_dst = 0; rec_type = 0; rd_idx = 0;
    m_ptr = 0;
    for (int i = 0; i < 32; i++) begin m_v[i] = 0; m_s[i] = 0; m_d[i] = 0; m_t[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state, all logical entries invalid, pointer zero
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, i, "R8 ptr");
    chk("R8 ptr after reset", 64'(wr_ptr), 64'd0);
    // R2: fill depth 16 past wrap, reading the slot being written (R9) at times
    for (int i = 0; i < 40; i++)
      step(1, 32'h1000 + i, 32'h2001 + 2 * i, 4'(i % 12), 0, (i % 3 == 0) ? 15 : i % 16, "R2 ptr");
    // R4: newest-first sweep
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, i, "R4 ptr");
    // R10: junk with rec_valid low
    for (int i = 0; i < 8; i++) step(0, 32'hdead0000 + i, 32'hbeef, 4'd13, 1, i, "R10 ptr");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, i, "R10 ptr");
    // R7: swap and return kinds stored normally outside call-stack mode
    step(1, 32'h3000, 32'h3100, 4'd12, 0, 0, "R7 ptr");
    step(1, 32'h3004, 32'h3105, 4'd13, 0, 0, "R7 ptr");
    step(0, 0, 0, 0, 0, 0, "R7 ptr");
    step(0, 0, 0, 0, 0, 1, "R7 ptr");
    // R5/R6: call-stack mode
    for (int i = 0; i < 5; i++) step(1, 32'h4000 + i, 32'h4101 + i, 4'd9, 1, 15, "R2 ptr");
    step(1, 32'h5000, 32'h5101, 4'd12, 1, 0, "R6 ptr");
    step(0, 0, 0, 0, 0, 0, "R6 ptr");
    step(1, 32'h5004, 32'h5105, 4'd13, 1, 0, "R5 ptr");
    step(0, 0, 0, 0, 0, 0, "R5 ptr");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 4'd13, 1, i % 2, "R5 ptr");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, i, "R5 ptr");
    // R1: depth 32 with wrap
    depth_sel = 1;
    for (int i = 0; i < 70; i++)
      step(1, 32'h6000 + i, 32'h7001 + i, 4'(i % 11), 0, (i % 4 == 0) ? 31 : i % 32, "R1 ptr");
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 0, i, "R1 ptr");
    // mixed random traffic, depth switches included
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (i % 150 == 149) depth_sel = ~depth_sel;
      step(r < 70, $urandom, $urandom, 4'($urandom_range(8, 13)), r % 2 == 0,
           int'($urandom_range(0, 31)), "R2 ptr");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule